// File: doc/BRIEF.md
# Power-on reset sequencer

This block produces the start-up reset for a device that has no reset input of any kind. Every flop in the block takes its power-up value from its declared initial value, which the configuration image loads. A start enable passes through a chain of synchronizer flops. Once it emerges, a down-counter that powered up at a preset length counts down to zero. Reaching zero ends the reset on a clock edge. After that the reset stays low until the device is configured again.

Two variants are selected by a parameter. In the fixed variant the enable is a constant one. In the pin variant the synchronizer is fed the inverted level of an external hold pin. The pin is pulled high before configuration completes and is tied low afterwards, so counting can only start after the pin falls. A second output reports that reset has been released and can drive an indicator LED directly.

Top module: `por_sequencer`

## Requirements
- R1: Without any reset input, `rst_out` is 1 and `released` is 0 from time zero, before the first clock edge.
- R2: The enable reaches the counter through SYNC_STAGES flip-flops (default 2). A change at the enable source affects counting only after SYNC_STAGES rising edges.
- R3: In the pin variant (USE_HOLD_PIN=1), a high level on `hold_pin` (1 = hold) forces the synchronizer flops to 0. While that 0 is at the synchronizer output, the counter does not move and `rst_out` stays 1.
- R4: While the synchronized enable is 1 and the count is nonzero, the count drops by exactly one per clock. When the enable goes back to 0, counting pauses and later resumes from the held value.
- R5: In the fixed variant, `rst_out` reads 1 after rising edges 1 to SYNC_STAGES+PRELOAD-1 and reads 0 after edge SYNC_STAGES+PRELOAD (default: edge 18).
- R6: `rst_out` is a flop output that changes only on a rising edge. Once it is 0 it never returns to 1, whatever `hold_pin` does afterwards.
- R7: `released` is always the inverse of `rst_out`.
- R8: PRELOAD is at least 1, so the reset lasts at least one full clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| hold_pin | input | 1 | External hold, 1 = keep reset; ignored when USE_HOLD_PIN=0 |
| rst_out | output | 1 | Active-high registered reset |
| released | output | 1 | 1 once reset has ended (LED drive) |

## Verification
A fall of the synchronized enable can arrive on the same edge where a decrement and the registered reset update would otherwise occur. When that happens, the count must freeze on exactly that edge and `rst_out` must keep its value. The bench provokes this by raising `hold_pin` again partway through the countdown, and later again after release. A behavioural model, built from a queue for the synchronizer delay and an integer count, is compared with both outputs of both variants on every clock. This judges the pause edge, the resume edge and the later pulse, which must be ignored.

// File: rtl/por_sequencer.sv
module por_sequencer #(
  parameter int SYNC_STAGES  = 2,
  parameter int PRELOAD      = 16,
  parameter bit USE_HOLD_PIN = 1'b1
) (
  input  logic clk,
  input  logic hold_pin,
  output logic rst_out,
  output logic released
);
  localparam int CW = $clog2(PRELOAD + 1);
  localparam logic [CW-1:0] LOAD = CW'(PRELOAD);

  logic                   src_en;
  logic [SYNC_STAGES-1:0] sync_q = '0;
  logic [CW-1:0]          cnt_q  = LOAD;
  logic [CW-1:0]          cnt_d;
  logic                   rst_q  = 1'b1;
  logic                   en;

  generate
    if (USE_HOLD_PIN) begin : g_pin
      assign src_en = ~hold_pin;
    end else begin : g_fixed
      assign src_en = 1'b1;
    end
  endgenerate

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) sync_q <= src_en;
    end else begin : g_chain
      always_ff @(posedge clk) sync_q <= {sync_q[SYNC_STAGES-2:0], src_en};
    end
  endgenerate

  assign en    = sync_q[SYNC_STAGES-1];
  assign cnt_d = (en && cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;

  always_ff @(posedge clk) begin
    cnt_q <= cnt_d;
    rst_q <= (cnt_d != '0);
  end

  assign rst_out  = rst_q;
  assign released = ~rst_q;

  initial begin
    if (PRELOAD < 1 || SYNC_STAGES < 1)
      $error("por_sequencer: PRELOAD and SYNC_STAGES must be at least 1");
  end

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  p_no_reassert_r6: assert property (@(posedge clk) disable iff (!armed)
    !rst_q |=> !rst_q);

  p_step_one_r4: assert property (@(posedge clk) disable iff (!armed)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) - 1'b1) && $past(en));

  p_hold_freezes_r3: assert property (@(posedge clk) disable iff (!armed)
    !en |=> $stable(cnt_q) && (rst_q || $past(!rst_q)));

  p_release_at_zero_r5: assert property (@(posedge clk) disable iff (!armed)
    $fell(rst_q) |-> (cnt_q == '0) && ($past(cnt_q) == 1));
endmodule

// File: tb/por_sequencer_test.sv
module por_sequencer_test;
  localparam int SYNC = 2;
  localparam int LOAD = 16;

  logic clk = 1'b0;
  logic hold_pin = 1'b1;
  logic rst_p, rel_p, rst_f, rel_f;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  por_sequencer #(.SYNC_STAGES(SYNC), .PRELOAD(LOAD), .USE_HOLD_PIN(1'b1)) uut (
    .clk(clk), .hold_pin(hold_pin), .rst_out(rst_p), .released(rel_p));

  por_sequencer #(.SYNC_STAGES(SYNC), .PRELOAD(LOAD), .USE_HOLD_PIN(1'b0)) uut_fixed (
    .clk(clk), .hold_pin(hold_pin), .rst_out(rst_f), .released(rel_f));

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  int qp[$];
  int qf[$];
  int cp = LOAD, cf = LOAD;
  int fixed_fall = -1;

  initial begin
    for (int i = 0; i < SYNC; i++) begin
      qp.push_back(0);
      qf.push_back(0);
    end
    #1;
    check("R1 pin rst", rst_p, 1'b1);
    check("R1 pin released", rel_p, 1'b0);
    check("R1 fixed rst", rst_f, 1'b1);
    check("R1 fixed released", rel_f, 1'b0);
    for (int k = 1; k <= 80; k++) begin
      @(posedge clk);
      begin
        int ep, ef;
        ep = qp[$]; ef = qf[$];
        qp.push_front(hold_pin ? 0 : 1); void'(qp.pop_back());
        qf.push_front(1); void'(qf.pop_back());
        if (ep != 0 && cp > 0) cp--;
        if (ef != 0 && cf > 0) cf--;
      end
      @(negedge clk);
      check("R3/R4 pin rst vs model", rst_p, cp != 0);
      check("R7 pin released", rel_p, ~rst_p);
      check("R2/R4 fixed rst vs model", rst_f, cf != 0);
      check("R7 fixed released", rel_f, ~rst_f);
      if (fixed_fall < 0 && rst_f === 1'b0) fixed_fall = k;
      if (k > SYNC + LOAD) check("R6 fixed stays released", rst_f, 1'b0);
      if (k < 10 + SYNC) check("R3 held pin keeps reset", rst_p, 1'b1);
      if ((k >= 0 && k < 10) || (k >= 17 && k < 22) || (k >= 50 && k < 55))
        hold_pin = 1'b1;
      else
        hold_pin = 1'b0;
    end
    total++;
    if (fixed_fall != SYNC + LOAD) begin
      bad++;
      $display("FAIL R5: actual=%0d expected=%0d (release edge)", fixed_fall, SYNC + LOAD);
    end
    total++;
    if (LOAD < 1) begin
      bad++;
      $display("FAIL R8: actual=%0d expected>=1", LOAD);
    end
    check("R6 pin stays released after late hold", rst_p, 1'b0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule